// File: doc/BRIEF.md
# Serial Key Gate for Debug Access

This block decides whether a debug host may read and execute protected memory. After a power-on reset it holds off for a fixed number of oscillator cycles while the line and the host settle. It then takes a snapshot of a 64-bit stored key and listens on a single half-duplex serial wire for eight bytes. Each byte arrives as an 8N1 frame, least significant bit first, on a line that idles high. The block compares each byte with the matching byte of the snapshot, then sends the byte back on the same wire so the host can check that the link is in step.

If all eight bytes match, a sticky unlock flag rises. Only a power-on reset clears the flag. A general reset leaves the flag as it is and closes the entry window, so a host that has already unlocked never has to send the key again. A single wrong byte, or a frame with a bad stop bit, marks the attempt as failed. The block still receives and echoes the remaining bytes so the host stays in step. A new attempt needs a new power-on reset.

Bit timing comes from an external tick strobe that runs at sixteen times the bit rate. The block samples the middle of each bit and drives the wire only while it sends an echo.

Top module: `keygate_top`

## Requirements
- R1: For the first SETTLE_CYCLES clock cycles after power-on reset is released, line activity is ignored. A frame sent in that period produces no echo and does not count as a key byte.
- R2: Incoming frames are 8N1 with the least significant bit first. The start bit is confirmed 8 ticks after it is detected, and each later bit is sampled 16 ticks after the one before it.
- R3: Each received byte is sent back as an 8N1 frame (start 0, data LSB first, stop 1) with lineOe high. The echo begins 2 bit times (32 ticks) after the end of the received stop bit. At all other times lineOe is 0 and lineOut is 1.
- R4: The next start bit is accepted after an idle gap of any length following an echo, from 1 bit time upward.
- R5: Received byte k is compared with keyVec[8k+7:8k], so byte 0 sits in the least significant byte. When all eight bytes match, unlocked rises at the stop-bit sample of the eighth byte.
- R6: If any byte differs from the key, unlocked stays 0. All eight bytes are still echoed.
- R7: A stop bit sampled low counts as a mismatch. That frame is still echoed, with a correct high stop bit.
- R8: keyVec is sampled once, when the settling period ends. Later changes to keyVec do not affect the comparison.
- R9: unlocked is 0 after power-on reset and keeps its value through a general reset (rstN low).
- R10: After the eighth byte has been echoed, or after any general reset, the line is ignored and nothing is echoed until the next power-on reset.
- R11: A low pulse that has ended by the half-bit check of the start bit is treated as noise. It is not received and produces no echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | General reset, active low, synchronous; closes the entry window |
| bitTick | input | 1 | One-cycle strobe at OVERSAMPLE times the bit rate |
| lineIn | input | 1 | Level seen on the shared serial wire |
| keyVec | input | KEY_BYTES*8 | Stored key, byte k in bits 8k+7:8k |
| lineOe | output | 1 | Drive enable for the shared wire, high only during an echo |
| lineOut | output | 1 | Value driven during an echo, 1 when not driving |
| unlocked | output | 1 | Sticky flag that permits protected reads and execution |

## Verification
On every cycle, the assertions check four things. The unlock and failure flags never fall without a power-on reset. The flag rises only when the last byte of a clean attempt has been checked. The receiver is never armed before settling ends. Each echo begins with a low start bit, and its level changes only on tick cycles. Other behaviour is shown only by the bench scenarios. These cover the two-bit echo delay measured at the pins, the echoed bit values, the effect of a wrong byte or bad stop bit placed at different positions, the key snapshot when keyVec changes after arming, and the silence after the window closes or after a general reset.

// File: rtl/keygate_pkg.sv
`timescale 1ns/1ps
package keygate_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_GAP,
    ST_ECHO,
    ST_DONE
  } gateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTick;
    logic clrBit;
    logic incBit;
    logic loadKey;
    logic shiftIn;
    logic checkByte;
    logic loadTx;
    logic shiftTx;
  } gateCmd_t;

endpackage

// File: rtl/keygate_datapath.sv
`timescale 1ns/1ps
module keygate_datapath
  import keygate_pkg::*;
#(
  parameter int KEY_BYTES     = 8,
  parameter int SETTLE_CYCLES = 4128,
  parameter int TICK_W        = 6,
  parameter int BIT_W         = 4
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic                   bitTick,
  input  logic                   lineIn,
  input  logic [KEY_BYTES*8-1:0] keyVec,
  input  gateCmd_t               cmd,
  output logic [TICK_W-1:0]      tickCnt,
  output logic [BIT_W-1:0]       bitCnt,
  output logic                   settleDone,
  output logic                   keyDone,
  output logic                   txBit,
  output logic                   unlocked
);

  localparam int IDX_W    = $clog2(KEY_BYTES + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam int TX_W     = 10;

  logic [SETTLE_W-1:0]          settleCnt;
  logic [KEY_BYTES-1:0][7:0]    keyReg;
  logic [7:0]                   rxShift;
  logic [TX_W-1:0]              txShift;
  logic [IDX_W-1:0]             byteIdx;
  logic                         failFlag;
  logic [KEY_BYTES-1:0]         matchVec;
  logic                         byteMatch;
  logic                         badByte;

  // settling interval counted in oscillator cycles, POR only
  assign settleDone = (settleCnt == SETTLE_W'(SETTLE_CYCLES));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) settleCnt <= '0;
    else if (!settleDone) settleCnt <= settleCnt + 1'b1;
  end

  // oversample tick counter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) tickCnt <= '0;
    else if (cmd.clrTick) tickCnt <= '0;
    else if (bitTick) tickCnt <= tickCnt + 1'b1;
  end

  // bit position within a frame
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) bitCnt <= '0;
    else if (cmd.clrBit) bitCnt <= '0;
    else if (cmd.incBit) bitCnt <= bitCnt + 1'b1;
  end

  // key snapshot taken once when the receiver arms
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) keyReg <= '0;
    else if (cmd.loadKey) keyReg <= keyVec;
  end

  // receive shifter, LSB first
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) rxShift <= '0;
    else if (cmd.shiftIn) rxShift <= {lineIn, rxShift[7:1]};
  end

  // per-position compare, one slot selected by the byte index
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_match
    assign matchVec[g] = (byteIdx == IDX_W'(g)) && (keyReg[g] == rxShift);
  end
  assign byteMatch = |matchVec;
  assign badByte   = !byteMatch || !lineIn;  // lineIn is the stop bit here
  assign keyDone   = (byteIdx == IDX_W'(KEY_BYTES));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      byteIdx  <= '0;
      failFlag <= 1'b0;
      unlocked <= 1'b0;
    end else if (cmd.checkByte) begin
      byteIdx  <= byteIdx + 1'b1;
      failFlag <= failFlag | badByte;
      if (byteIdx == IDX_W'(KEY_BYTES - 1) && !failFlag && !badByte)
        unlocked <= 1'b1;
    end
  end

  // transmit shifter: stop, data, start; shifts ones in behind
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) txShift <= '1;
    else if (cmd.loadTx) txShift <= {1'b1, rxShift, 1'b0};
    else if (cmd.shiftTx) txShift <= {1'b1, txShift[TX_W-1:1]};
  end
  assign txBit = txShift[0];

  // R9
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    !$fell(unlocked));

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    !$fell(failFlag));

  // R5
  unlock_clean_last_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(unlocked) |-> (keyDone && !failFlag));

  // R10
  byte_bound_chk: assert property (@(posedge clk) disable iff (!porN)
    byteIdx <= IDX_W'(KEY_BYTES));

endmodule

// File: rtl/keygate_ctrl.sv
`timescale 1ns/1ps
module keygate_ctrl
  import keygate_pkg::*;
#(
  parameter int OVERSAMPLE      = 16,
  parameter int ECHO_DELAY_BITS = 2,
  parameter int TICK_W          = 6,
  parameter int BIT_W           = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              lineIn,
  input  logic [TICK_W-1:0] tickCnt,
  input  logic [BIT_W-1:0]  bitCnt,
  input  logic              settleDone,
  input  logic              keyDone,
  output gateCmd_t          cmd,
  output logic              echoActive
);

  localparam int HALF_TICKS = OVERSAMPLE / 2;
  localparam int GAP_TICKS  = HALF_TICKS + ECHO_DELAY_BITS * OVERSAMPLE;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;

  gateState_t state, nextState;
  logic atHalf, atFull, atGap;

  assign atHalf = bitTick && (tickCnt == TICK_W'(HALF_TICKS - 1));
  assign atFull = bitTick && (tickCnt == TICK_W'(OVERSAMPLE - 1));
  assign atGap  = bitTick && (tickCnt == TICK_W'(GAP_TICKS - 1));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_SETTLE;
    else if (!rstN) state <= ST_DONE;   // window closes, flag untouched
    else state <= nextState;
  end

  always_comb begin
    nextState  = state;
    cmd        = '0;
    echoActive = 1'b0;
    case (state)
      ST_SETTLE: if (settleDone) begin
        cmd.loadKey = 1'b1;
        nextState   = ST_IDLE;
      end
      ST_IDLE: if (bitTick && !lineIn) begin
        cmd.clrTick = 1'b1;
        nextState   = ST_START;
      end
      ST_START: if (atHalf) begin
        cmd.clrTick = 1'b1;
        cmd.clrBit  = 1'b1;
        nextState   = lineIn ? ST_IDLE : ST_DATA;
      end
      ST_DATA: if (atFull) begin
        cmd.clrTick = 1'b1;
        cmd.shiftIn = 1'b1;
        cmd.incBit  = 1'b1;
        if (bitCnt == BIT_W'(DATA_BITS - 1)) nextState = ST_STOP;
      end
      ST_STOP: if (atFull) begin
        cmd.clrTick   = 1'b1;
        cmd.checkByte = 1'b1;
        nextState     = ST_GAP;
      end
      ST_GAP: if (atGap) begin
        cmd.clrTick = 1'b1;
        cmd.clrBit  = 1'b1;
        cmd.loadTx  = 1'b1;
        nextState   = ST_ECHO;
      end
      ST_ECHO: begin
        echoActive = 1'b1;
        if (atFull) begin
          cmd.clrTick = 1'b1;
          cmd.shiftTx = 1'b1;
          cmd.incBit  = 1'b1;
          if (bitCnt == BIT_W'(FRAME_BITS - 1))
            nextState = keyDone ? ST_DONE : ST_IDLE;
        end
      end
      ST_DONE: nextState = ST_DONE;
      default: nextState = ST_DONE;
    endcase
  end

  // R1
  armed_after_settle_chk: assert property (@(posedge clk) disable iff (!porN)
    (state inside {ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_GAP, ST_ECHO}) |-> settleDone);

endmodule

// File: rtl/keygate_top.sv
`timescale 1ns/1ps
module keygate_top
  import keygate_pkg::*;
#(
  parameter int KEY_BYTES       = 8,
  parameter int SETTLE_CYCLES   = 4128,
  parameter int OVERSAMPLE      = 16,
  parameter int ECHO_DELAY_BITS = 2
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic                   rstN,
  input  logic                   bitTick,
  input  logic                   lineIn,
  input  logic [KEY_BYTES*8-1:0] keyVec,
  output logic                   lineOe,
  output logic                   lineOut,
  output logic                   unlocked
);

  localparam int GAP_TICKS = OVERSAMPLE / 2 + ECHO_DELAY_BITS * OVERSAMPLE;
  localparam int TICK_W    = $clog2(GAP_TICKS + 1);
  localparam int BIT_W     = $clog2(10 + 1);

  gateCmd_t          cmd;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              settleDone, keyDone, txBit, echoActive;

  keygate_ctrl #(
    .OVERSAMPLE(OVERSAMPLE), .ECHO_DELAY_BITS(ECHO_DELAY_BITS),
    .TICK_W(TICK_W), .BIT_W(BIT_W)
  ) i_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .bitTick(bitTick), .lineIn(lineIn),
    .tickCnt(tickCnt), .bitCnt(bitCnt), .settleDone(settleDone),
    .keyDone(keyDone), .cmd(cmd), .echoActive(echoActive)
  );

  keygate_datapath #(
    .KEY_BYTES(KEY_BYTES), .SETTLE_CYCLES(SETTLE_CYCLES),
    .TICK_W(TICK_W), .BIT_W(BIT_W)
  ) i_datapath (
    .clk(clk), .porN(porN), .bitTick(bitTick), .lineIn(lineIn), .keyVec(keyVec),
    .cmd(cmd), .tickCnt(tickCnt), .bitCnt(bitCnt), .settleDone(settleDone),
    .keyDone(keyDone), .txBit(txBit), .unlocked(unlocked)
  );

  assign lineOe  = echoActive;
  assign lineOut = echoActive ? txBit : 1'b1;

  // R3
  echo_start_low_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(lineOe) |-> !lineOut);

  // R3
  echo_bit_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (lineOe && $past(lineOe) && !$past(bitTick)) |-> $stable(lineOut));

endmodule

// File: tb/test_keygate_top.sv
`timescale 1ns/1ps
module test_keygate_top;

  localparam int SETTLE   = 4128;
  localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rstN = 1'b1;
  logic        tickPh = 1'b0;
  logic        bitTick;
  logic        hostLine = 1'b1;
  logic        lineIn;
  logic [63:0] keyVec = '0;
  logic        lineOe, lineOut, unlocked;
  int          compared = 0;
  int          mismatched = 0;
  logic        finished = 1'b0;

  always #10 clk = ~clk;
  always_ff @(posedge clk) tickPh <= ~tickPh;
  assign bitTick = tickPh;
  assign lineIn  = lineOe ? lineOut : hostLine;

  keygate_top i_keygate_top (
    .clk(clk), .porN(porN), .rstN(rstN), .bitTick(bitTick), .lineIn(lineIn),
    .keyVec(keyVec), .lineOe(lineOe), .lineOut(lineOut), .unlocked(unlocked)
  );

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(string req, string what, int act, int lo, int hi);
    compared++;
    if (act < lo || act > hi) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic logic [63:0] keyFor(int s);
    logic [63:0] k;
    for (int b = 0; b < 8; b++) k[8*b +: 8] = 8'((s * 53 + b * 29 + 7) ^ (b << 4));
    return k;
  endfunction

  task automatic sendFrame(logic [7:0] b, logic stopBit);
    @(negedge clk) hostLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hostLine = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    hostLine = stopBit;
    repeat (BIT_CLKS) @(negedge clk);
    hostLine = 1'b1;
  endtask

  // called right at the end of the host stop bit
  task automatic expectEcho(string req, logic [7:0] b, int gapBits);
    int waitCnt = 0;
    logic expBit;
    while (!lineOe && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    // R3: two bit times (64 clocks) after the stop bit ends, plus detect jitter
    checkRange({req, " R3"}, "echo delay clocks", waitCnt, 62, 68);
    repeat (BIT_CLKS / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      expBit = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      // R2: echoed bits equal the LSB-first received byte
      check({req, " R2"}, $sformatf("echo bit %0d oe/val", i),
            int'({lineOe, lineOut}), int'({1'b1, expBit}));
      repeat (BIT_CLKS) @(negedge clk);
    end
    check({req, " R3"}, "line released after echo",
          int'({lineOe, lineOut}), int'({1'b0, 1'b1}));
    repeat (gapBits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic expectSilence(string req, int clocks);
    int seen = 0;
    repeat (clocks) begin
      @(negedge clk);
      if (lineOe) seen = 1;
    end
    check(req, "no echo", seen, 0);
  endtask

  task automatic pulsePor();
    @(negedge clk) porN = 1'b0;
    repeat (4) @(negedge clk);
    porN = 1'b1;
  endtask

  task automatic pulseRst();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // send the eight bytes; wrongIdx corrupts one byte, badStopIdx drops one stop bit
  task automatic enterKey(logic [63:0] key, int wrongIdx, int badStopIdx, int gapSeed);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) begin
      b = key[8*k +: 8];
      if (k == wrongIdx) b = b ^ 8'h10;
      if (k == 7) check("R5", "flag clear before last byte", int'(unlocked), 0);
      sendFrame(b, (k == badStopIdx) ? 1'b0 : 1'b1);
      // R4: gaps of 1, 5 or 9 bit times between echo and next start
      expectEcho((k == 0) ? "R2" : "R4", b, 1 + ((k + gapSeed) % 3) * 4);
    end
  endtask

  initial begin
    logic [63:0] k0;
    logic [63:0] kk;
    int          wrongAt;
    k0 = keyFor(11);
    keyVec = k0;

    // reset state
    repeat (5) @(negedge clk);
    check("R3", "reset lineOe", int'(lineOe), 0);
    check("R3", "reset lineOut", int'(lineOut), 1);
    check("R9", "reset unlocked", int'(unlocked), 0);

    // R1: a frame during settling is ignored
    porN = 1'b1;
    repeat (50) @(negedge clk);
    sendFrame(8'hA5, 1'b1);
    expectSilence("R1", SETTLE - 50 - 330 - 40);
    repeat (200) @(negedge clk);

    // R8: key changes after arming must not matter
    keyVec = ~k0;

    // R11: short low glitch is noise
    @(negedge clk) hostLine = 1'b0;
    repeat (4) @(negedge clk);
    hostLine = 1'b1;
    expectSilence("R11", 150);

    enterKey(k0, -1, -1, 0);
    check("R5", "unlocked after clean key", int'(unlocked), 1);
    check("R8", "snapshot key used", int'(unlocked), 1);

    // R10: window closed after eight bytes
    sendFrame(k0[7:0], 1'b1);
    expectSilence("R10", 200);

    // R9: general reset keeps the flag; R10: still no entry
    pulseRst();
    check("R9", "unlocked after general reset", int'(unlocked), 1);
    sendFrame(k0[7:0], 1'b1);
    expectSilence("R10", 200);

    pulsePor();
    check("R9", "unlocked cleared by power-on", int'(unlocked), 0);

    // R6: one wrong byte, all still echoed
    kk = keyFor(3);
    keyVec = kk;
    repeat (SETTLE + 80) @(negedge clk);
    enterKey(kk, 3, -1, 1);
    check("R6", "wrong byte keeps lock", int'(unlocked), 0);

    // R7: bad stop bit counts as mismatch
    pulsePor();
    kk = keyFor(4);
    keyVec = kk;
    repeat (SETTLE + 80) @(negedge clk);
    enterKey(kk, -1, 5, 2);
    check("R7", "bad stop keeps lock", int'(unlocked), 0);

    // R10: general reset mid-window
    pulsePor();
    kk = keyFor(5);
    keyVec = kk;
    repeat (SETTLE + 80) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sendFrame(kk[8*k +: 8], 1'b1);
      expectEcho("R2", kk[8*k +: 8], 1);
    end
    pulseRst();
    sendFrame(kk[31:24], 1'b1);
    expectSilence("R10", 200);
    check("R10", "no unlock after window closed", int'(unlocked), 0);

    // sweep over keys; odd runs fail at the first or last position
    for (int s = 0; s < 4; s++) begin
      pulsePor();
      kk = keyFor(20 + s);
      keyVec = kk;
      repeat (SETTLE + 80) @(negedge clk);
      wrongAt = (s == 1) ? 7 : (s == 3) ? 0 : -1;
      enterKey(kk, wrongAt, -1, s);
      check((wrongAt < 0) ? "R5" : "R6", $sformatf("sweep %0d flag", s),
            int'(unlocked), (wrongAt < 0) ? 1 : 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule